// File: doc/BRIEF.md
# Remappable Memory Map Decoder

This block turns a 16-bit CPU address into exactly one of three region selects: a 256-byte on-chip static RAM, an on-chip EEPROM window, or the external bus. The RAM does not sit at a fixed place. A 4-bit remap register names the 4K partition whose first 256 bytes hold the RAM. After reset, that partition is the lowest one.

Instructions that use short (direct) addressing carry only the low address byte. For these accesses the block builds the full effective address. The top four bits come from the remap register, the next four bits are zero, and the low byte comes from the instruction. A direct access therefore always lands in the RAM, wherever the RAM has been moved.

The effective address and the selects come out of registers. They appear on the clock edge after the address is presented. The remap register is loaded through a simple write-enable and data port.

Top module: `memmap_decoder`

## Requirements
- R1: While `rst` is high, the outputs `ram_sel`, `eeprom_sel`, `ext_sel` and `eff_addr` are all zero, and the remap register is cleared to 4'h0.
- R2: With the remap value still at its reset value of 0, addresses 16'h0000 through 16'h00FF select the RAM, and 16'h0100 does not.
- R3: A write with `remap_we` high loads `remap_wdata` at that clock edge. The new value is first used to decode the address that is sampled on the following edge. The address sampled on the same edge as the write is decoded with the old value.
- R4: `ram_sel` is asserted exactly when bits [15:12] of the effective address equal the remap value and bits [11:8] are zero.
- R5: `eeprom_sel` is asserted for effective addresses 16'hB600 through 16'hB7FF that do not hit the RAM.
- R6: `ext_sel` is asserted for every effective address that hits neither the RAM nor the EEPROM window.
- R7: Outside reset, exactly one of the three selects is high in each cycle after the first decode. The RAM takes priority over the EEPROM window.
- R8: When `direct_mode` is high, the effective address is {remap, 4'b0000, cpu_addr[7:0]}. `cpu_addr[15:8]` is ignored, and the access selects the RAM.
- R9: When `direct_mode` is low, the effective address equals `cpu_addr`.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. A new address does not change the outputs before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address; in direct mode only the low byte is used |
| direct_mode | input | 1 | High for a short-address (direct) access |
| remap_we | input | 1 | Write enable for the remap register |
| remap_wdata | input | 4 | New 4K partition number for the RAM |
| eff_addr | output | 16 | Registered effective address |
| ram_sel | output | 1 | Registered on-chip RAM select |
| eeprom_sel | output | 1 | Registered EEPROM window select |
| ext_sel | output | 1 | Registered external region select |

## Verification
The assertions assume that `direct_mode`, `remap_we` and `remap_wdata` are never X or Z once reset is released. They also assume that reset is held for at least one clock edge, so the output registers start from zero. The bench drives every input on the falling edge and holds it for a whole cycle. It drops `remap_we` after a single cycle, except in the one scenario that deliberately overlaps a write with a decode. It keeps the default EEPROM base, so the RAM and the EEPROM window never share an address.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  typedef struct packed {
    logic ram;
    logic ee;
    logic ext;
  } sel_t;

  localparam sel_t SEL_NONE = '{ram: 1'b0, ee: 1'b0, ext: 1'b0};
endpackage

// File: rtl/remap_reg.sv
module remap_reg #(
  parameter int PART_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PART_W-1:0] wdata,
  output logic [PART_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  AST_REMAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata))); // R3
  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R3
endmodule

// File: rtl/addr_former.sv
module addr_former #(
  parameter int ADDR_W = 16,
  parameter int PART_W = 4,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              direct_mode,
  input  logic [PART_W-1:0] remap,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int MID_W = ADDR_W - PART_W - PAGE_W;

  always_comb begin
    if (direct_mode) eff_addr = {remap, {MID_W{1'b0}}, cpu_addr[PAGE_W-1:0]};
    else             eff_addr = cpu_addr;
  end
endmodule

// File: rtl/region_decode.sv
module region_decode
  import memmap_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              PART_W  = 4,
  parameter int              PAGE_W  = 8,
  parameter logic [15:0]     EE_BASE = 16'hB600,
  parameter int              EE_LOG2 = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PART_W-1:0] remap,
  output sel_t              sel
);
  localparam int MID_LO = PAGE_W;
  localparam int MID_HI = ADDR_W - PART_W - 1;
  localparam logic [ADDR_W-1:0] EE_B = ADDR_W'(EE_BASE);

  logic ram_hit;
  logic ee_hit;

  always_comb begin
    ram_hit = (addr[ADDR_W-1 -: PART_W] == remap) && (addr[MID_HI:MID_LO] == '0);
    ee_hit  = (addr[ADDR_W-1:EE_LOG2] == EE_B[ADDR_W-1:EE_LOG2]);
    sel     = SEL_NONE;
    if (ram_hit)     sel.ram = 1'b1;
    else if (ee_hit) sel.ee  = 1'b1;
    else             sel.ext = 1'b1;
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          PART_W  = 4,
  parameter int          PAGE_W  = 8,
  parameter logic [15:0] EE_BASE = 16'hB600,
  parameter int          EE_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              direct_mode,
  input  logic              remap_we,
  input  logic [PART_W-1:0] remap_wdata,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              ram_sel,
  output logic              eeprom_sel,
  output logic              ext_sel
);
  localparam int MID_HI = ADDR_W - PART_W - 1;
  localparam logic [ADDR_W-1:0] EE_B  = ADDR_W'(EE_BASE);
  localparam logic [ADDR_W-1:0] EE_HI = EE_B + ADDR_W'((1 << EE_LOG2) - 1);

  logic [PART_W-1:0] remap_q;
  logic [ADDR_W-1:0] eff_c;
  sel_t              sel_c;
  sel_t              sel_q;

  remap_reg #(.PART_W(PART_W)) u_remap (
    .clk   (clk),
    .rst   (rst),
    .we    (remap_we),
    .wdata (remap_wdata),
    .q     (remap_q)
  );

  addr_former #(.ADDR_W(ADDR_W), .PART_W(PART_W), .PAGE_W(PAGE_W)) u_form (
    .cpu_addr    (cpu_addr),
    .direct_mode (direct_mode),
    .remap       (remap_q),
    .eff_addr    (eff_c)
  );

  region_decode #(
    .ADDR_W(ADDR_W), .PART_W(PART_W), .PAGE_W(PAGE_W),
    .EE_BASE(EE_BASE), .EE_LOG2(EE_LOG2)
  ) u_dec (
    .addr  (eff_c),
    .remap (remap_q),
    .sel   (sel_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_addr <= '0;
      sel_q    <= SEL_NONE;
    end else begin
      eff_addr <= eff_c;
      sel_q    <= sel_c;
    end
  end

  assign ram_sel    = sel_q.ram;
  assign eeprom_sel = sel_q.ee;
  assign ext_sel    = sel_q.ext;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!ram_sel && !eeprom_sel && !ext_sel && eff_addr == '0)); // R1
  AST_ONE_SELECT: assert property (@(posedge clk)
    $onehot0({ram_sel, eeprom_sel, ext_sel})); // R7
  AST_DIRECT_RAM: assert property (@(posedge clk) disable iff (rst)
    direct_mode |=> ram_sel); // R8
  AST_RAM_PAGE: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> (eff_addr[MID_HI:PAGE_W] == '0)); // R4
  AST_EE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    eeprom_sel |-> (eff_addr >= EE_B && eff_addr <= EE_HI)); // R5
  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (rst)
    !direct_mode |=> (eff_addr == $past(cpu_addr))); // R9
endmodule

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        direct_mode;
  logic        remap_we;
  logic [3:0]  remap_wdata;
  logic [15:0] eff_addr;
  logic        ram_sel, eeprom_sel, ext_sel;

  int errors = 0;
  int checks = 0;
  logic [3:0] remap_m = 4'h0;

  always #4 clk = ~clk;

  memmap_decoder u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .direct_mode(direct_mode),
    .remap_we(remap_we), .remap_wdata(remap_wdata), .eff_addr(eff_addr),
    .ram_sel(ram_sel), .eeprom_sel(eeprom_sel), .ext_sel(ext_sel)
  );

  function automatic logic [15:0] model_eff(logic [15:0] a, logic d, logic [3:0] rm);
    return d ? {rm, 4'h0, a[7:0]} : a;
  endfunction

  function automatic logic [2:0] model_sel(logic [15:0] e, logic [3:0] rm);
    if (e[15:12] == rm && e[11:8] == 4'h0) return 3'b100;
    if (e >= 16'hB600 && e <= 16'hB7FF)    return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(string req, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual eff=%h sel=%b expected eff=%h sel=%b",
               req, act[18:3], act[2:0], exp[18:3], exp[2:0]);
    end
  endtask

  // drive at negedge, decode at posedge, sample at the following negedge
  task automatic access(string req, logic [15:0] a, logic d);
    cpu_addr = a; direct_mode = d;
    @(negedge clk);
    check(req, {eff_addr, ram_sel, eeprom_sel, ext_sel},
          {model_eff(a, d, remap_m), model_sel(model_eff(a, d, remap_m), remap_m)});
  endtask

  task automatic write_remap(logic [3:0] v);
    remap_we = 1'b1; remap_wdata = v;
    @(negedge clk);
    remap_we = 1'b0;
    remap_m = v;
  endtask

  task automatic t_reset;
    rst = 1'b1; cpu_addr = 16'h1234; direct_mode = 1'b0;
    remap_we = 1'b0; remap_wdata = 4'h0;
    repeat (3) @(negedge clk);
    check("R1", {eff_addr, ram_sel, eeprom_sel, ext_sel}, 19'd0);
    rst = 1'b0;
  endtask

  task automatic t_reset_map;
    access("R2", 16'h0000, 1'b0);
    access("R2", 16'h00FF, 1'b0);
    access("R2", 16'h0100, 1'b0);
    access("R4", 16'h1000, 1'b0);
    access("R9", 16'hFFFF, 1'b0);
  endtask

  task automatic t_eeprom;
    access("R5", 16'hB600, 1'b0);
    access("R5", 16'hB7FF, 1'b0);
    access("R6", 16'hB5FF, 1'b0);
    access("R6", 16'hB800, 1'b0);
  endtask

  task automatic t_remap;
    write_remap(4'h7);
    access("R4", 16'h7000, 1'b0);
    access("R4", 16'h70FF, 1'b0);
    access("R3", 16'h0000, 1'b0);
    access("R6", 16'h7100, 1'b0);
  endtask

  task automatic t_write_timing;
    // address presented on the same edge as the write uses the old value 7
    cpu_addr = 16'h3010; direct_mode = 1'b0;
    remap_we = 1'b1; remap_wdata = 4'h3;
    @(negedge clk);
    remap_we = 1'b0;
    check("R3", {eff_addr, ram_sel, eeprom_sel, ext_sel}, {16'h3010, 3'b001});
    remap_m = 4'h3;
    access("R3", 16'h3010, 1'b0);
  endtask

  task automatic t_direct;
    access("R8", 16'hFF42, 1'b1);
    access("R8", 16'hB6A5, 1'b1);
    write_remap(4'hB);
    access("R8", 16'h0010, 1'b1);
    access("R7", 16'hB600, 1'b0);
    access("R7", 16'hB000, 1'b0);
    write_remap(4'hF);
    access("R4", 16'hF0FF, 1'b0);
    access("R8", 16'h00FF, 1'b1);
  endtask

  task automatic t_latency;
    access("R10", 16'hF000, 1'b0);
    cpu_addr = 16'hB601; direct_mode = 1'b0;
    @(posedge clk);
    #1;
    // still just before nothing: sampled 1ns after edge, new value present
    check("R10", {eff_addr, ram_sel, eeprom_sel, ext_sel}, {16'hB601, 3'b010});
    cpu_addr = 16'h0000;
    #2;
    // input changed mid-cycle; registered outputs must not follow it
    check("R10", {eff_addr, ram_sel, eeprom_sel, ext_sel}, {16'hB601, 3'b010});
    @(negedge clk);
  endtask

  initial begin
    t_reset;
    t_reset_map;
    t_eeprom;
    t_remap;
    t_write_timing;
    t_direct;
    t_latency;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule